// File: doc/BRIEF.md
# Double-Buffered Compare PWM Generator

The block is a 16-bit PWM timebase with a power-of-two prescaler and seven compare slots. A counter runs from a start value up to an end value and then wraps back to the start value. The start value may be negative, so a symmetric range such as -5 to +4 is allowed. A mid slot marks the half-period point. Each of the two outputs, A and B, is set when the count equals its own "on" slot and cleared when the count equals its own "off" slot. Edge-aligned and centre-aligned waveforms differ only in the slot values that are programmed.

Software writes new slot values into a staging copy through a plain write port. It then raises a load-OK request. A two-state reload controller copies the whole staging copy into the active copy, either straight away or at the next chosen boundary. The boundary can be the half-period point, the wrap, or both. A divider can skip boundaries, so the copy happens only at every (N+1)th one. The controller's states are LD_IDLE and LD_ARMED. A load-OK request moves it from LD_IDLE to LD_ARMED. A transfer moves it from LD_ARMED back to LD_IDLE. The controller starts in LD_IDLE after reset. One-cycle half-period and wrap strobes are driven out so that other logic can follow the period.

Top module: `pwm_cmp_gen`

## Requirements
- R1: While reset is low, and on the first cycles after it is released, `out_a`, `out_b` and `ldok_o` are 0.
- R2: On every prescaled tick the count steps by one. On the tick where the count equals the end slot, it wraps to the start slot instead. A period is therefore (end - start + 1) ticks, with values compared as signed 16-bit numbers. `full_stb` gives a one-cycle pulse once per period, in the cycle after the wrap tick.
- R3: `half_stb` gives a one-cycle pulse after the tick where the count equals the mid slot. It comes (end - mid) ticks before the `full_stb` of the same period.
- R4: `out_a` rises after the tick where the count equals slot 3 and falls after the tick where it equals slot 4, so it stays high for (slot4 - slot3) ticks. `out_b` does the same with slots 5 and 6.
- R5: When the on and off slots of a channel hold the same value, the clear wins, and that output stays constantly low.
- R6: A tick occurs every 2^P clock cycles, where P is control bits [2:0].
- R7: A write stores `wr_data` at `wr_addr`. Addresses 0 to 6 are the staging slots: start, mid, end, A on, A off, B on, B off. Address 7 is control: [2:0] prescale exponent, [3] immediate mode, [4] half-period enable, [5] wrap enable, [9:6] reload skip count N, and [15] a load-OK request (writing 1 sets it).
- R8: In immediate mode, load-OK clears in the clock after the one that set it, and the staged values take effect from then on.
- R9: Outside immediate mode, a transfer happens only at an enabled boundary. `ldok_o` falls in the same cycle that `half_stb` (half-period enabled) or `full_stb` (wrap enabled) pulses.
- R10: Only every (N+1)th enabled boundary allows a transfer. The boundary count restarts from zero on every control write.
- R11: Load-OK clears itself on a transfer. Writes to addresses 0 to 6 are ignored while it is set.
- R12: Staged values have no effect on the outputs until a transfer. A transfer at a wrap restarts the count at the newly staged start value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write address (slots 0-6, control 7) |
| wr_data | input | 16 | Write data |
| out_a | output | 1 | PWM output A |
| out_b | output | 1 | PWM output B |
| half_stb | output | 1 | Pulse after the mid-slot tick |
| full_stb | output | 1 | Pulse after the wrap tick |
| ldok_o | output | 1 | Load-OK pending (reload controller in LD_ARMED) |

## Verification
Two events can fall on the same clock edge: a staged transfer and the counter wrap. When the wrap boundary is selected, the transfer must seed the new start value into that same wrap. The bench provokes this by staging a negative start value with the wrap boundary enabled. It then measures the period and the half-to-wrap gap afterwards; a stale start value would show up as a wrong period. The set and clear compares of one channel can also coincide. This is provoked by programming equal on and off slots and judged by watching that output stay low across several periods.

// File: rtl/pwm_cmp_pkg.sv
package pwm_cmp_pkg;
    localparam int NSLOT     = 7;
    localparam int NCH       = 2;
    localparam int ADDR_W    = $clog2(NSLOT + 1);
    localparam int SLOT_INIT = 0;
    localparam int SLOT_MID  = 1;
    localparam int SLOT_END  = 2;
    localparam int SLOT_AON  = 3;
    localparam int SLOT_AOFF = 4;
    localparam int SLOT_BON  = 5;
    localparam int SLOT_BOFF = 6;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(NSLOT);

    typedef enum logic {
        LD_IDLE  = 1'b0,
        LD_ARMED = 1'b1
    } ld_state_e;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int PSW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [PSW-1:0] exp_i,
    output logic           tick_o
);
    localparam int CW = (1 << PSW) - 1;

    logic [CW-1:0] pcnt_q;
    logic [CW-1:0] lim;

    // terminal count is 2^exp - 1
    assign lim    = ~({CW{1'b1}} << exp_i);
    assign tick_o = (pcnt_q == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pcnt_q <= '0;
        else if (tick_o) pcnt_q <= '0;
        else             pcnt_q <= pcnt_q + CW'(1);
    end
endmodule

// File: rtl/pwm_reload_fsm.sv
module pwm_reload_fsm import pwm_cmp_pkg::*; #(
    parameter int FW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_i,
    input  logic          imm_i,
    input  logic          half_en_i,
    input  logic          full_en_i,
    input  logic [FW-1:0] every_i,
    input  logic          div_clr_i,
    input  logic          half_opp_i,
    input  logic          full_opp_i,
    output logic          load_o,
    output logic          armed_o
);
    ld_state_e     state_q, state_d;
    logic [FW-1:0] div_q;
    logic          opp, due;

    assign opp = (half_en_i && half_opp_i) || (full_en_i && full_opp_i);
    assign due = opp && (div_q == every_i);

    // boundary divider: lets through every (N+1)th enabled boundary
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         div_q <= '0;
        else if (div_clr_i) div_q <= '0;
        else if (opp)       div_q <= (div_q == every_i) ? '0 : div_q + FW'(1);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LD_IDLE;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        load_o  = 1'b0;
        armed_o = 1'b0;
        unique case (state_q)
            LD_IDLE: begin
                if (set_i) state_d = LD_ARMED;
            end
            LD_ARMED: begin
                armed_o = 1'b1;
                load_o  = imm_i || due;
                if (load_o) state_d = LD_IDLE;
            end
        endcase
    end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase import pwm_cmp_pkg::*; #(
    parameter int DW = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick_i,
    input  logic                    load_i,
    input  logic [DW-1:0]           init_i,
    input  logic [DW-1:0]           next_init_i,
    input  logic [DW-1:0]           mid_i,
    input  logic [DW-1:0]           end_i,
    input  logic [NCH-1:0][DW-1:0]  on_i,
    input  logic [NCH-1:0][DW-1:0]  off_i,
    output logic                    half_opp_o,
    output logic                    full_opp_o,
    output logic                    half_stb_o,
    output logic                    full_stb_o,
    output logic [NCH-1:0]          wave_o,
    output logic [DW-1:0]           cnt_o
);
    logic [DW-1:0] cnt_q;

    assign cnt_o      = cnt_q;
    assign half_opp_o = tick_i && (cnt_q == mid_i);
    assign full_opp_o = tick_i && (cnt_q == end_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            if (full_opp_o) cnt_q <= load_i ? next_init_i : init_i;
            else            cnt_q <= cnt_q + DW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_stb_o <= 1'b0;
            full_stb_o <= 1'b0;
        end else begin
            half_stb_o <= half_opp_o;
            full_stb_o <= full_opp_o;
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                wave_o[g] <= 1'b0;
            end else if (tick_i) begin
                if (cnt_q == off_i[g])     wave_o[g] <= 1'b0;
                else if (cnt_q == on_i[g]) wave_o[g] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/pwm_cmp_gen.sv
module pwm_cmp_gen import pwm_cmp_pkg::*; #(
    parameter int DW  = 16,
    parameter int PSW = 3,
    parameter int FW  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    output logic              out_a,
    output logic              out_b,
    output logic              half_stb,
    output logic              full_stb,
    output logic              ldok_o
);
    localparam int B_IMM  = PSW;
    localparam int B_HALF = PSW + 1;
    localparam int B_FULL = PSW + 2;
    localparam int B_EVRY = PSW + 3;

    logic [NSLOT-1:0][DW-1:0] stage_q, act_q;
    logic [NCH-1:0][DW-1:0]   on_v, off_v;
    logic [NCH-1:0]           wave;
    logic [PSW-1:0]           psc_q;
    logic [FW-1:0]            every_q;
    logic                     imm_q, half_en_q, full_en_q;
    logic                     ctrl_wr, slot_wr, ld_set;
    logic                     tick, load, armed, half_opp, full_opp;
    logic [DW-1:0]            cnt;

    assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);
    assign slot_wr = wr_en && (wr_addr != ADDR_CTRL) && !armed;
    assign ld_set  = ctrl_wr && wr_data[DW-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psc_q     <= '0;
            imm_q     <= 1'b0;
            half_en_q <= 1'b0;
            full_en_q <= 1'b0;
            every_q   <= '0;
        end else if (ctrl_wr) begin
            psc_q     <= wr_data[PSW-1:0];
            imm_q     <= wr_data[B_IMM];
            half_en_q <= wr_data[B_HALF];
            full_en_q <= wr_data[B_FULL];
            every_q   <= wr_data[B_EVRY +: FW];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       stage_q <= '0;
        else if (slot_wr) stage_q[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    act_q <= '0;
        else if (load) act_q <= stage_q;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_map
        assign on_v[g]  = act_q[SLOT_AON + 2*g];
        assign off_v[g] = act_q[SLOT_AOFF + 2*g];
    end

    pwm_prescaler #(.PSW(PSW)) u_psc (
        .clk    (clk),
        .rst_n  (rst_n),
        .exp_i  (psc_q),
        .tick_o (tick)
    );

    pwm_reload_fsm #(.FW(FW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (ld_set),
        .imm_i      (imm_q),
        .half_en_i  (half_en_q),
        .full_en_i  (full_en_q),
        .every_i    (every_q),
        .div_clr_i  (ctrl_wr),
        .half_opp_i (half_opp),
        .full_opp_i (full_opp),
        .load_o     (load),
        .armed_o    (armed)
    );

    pwm_timebase #(.DW(DW)) u_tb (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .load_i      (load),
        .init_i      (act_q[SLOT_INIT]),
        .next_init_i (stage_q[SLOT_INIT]),
        .mid_i       (act_q[SLOT_MID]),
        .end_i       (act_q[SLOT_END]),
        .on_i        (on_v),
        .off_i       (off_v),
        .half_opp_o  (half_opp),
        .full_opp_o  (full_opp),
        .half_stb_o  (half_stb),
        .full_stb_o  (full_stb),
        .wave_o      (wave),
        .cnt_o       (cnt)
    );

    assign out_a  = wave[0];
    assign out_b  = wave[1];
    assign ldok_o = armed;
endmodule

// File: rtl/pwm_cmp_chk.sv
module pwm_cmp_chk import pwm_cmp_pkg::*; #(
    parameter int DW = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     wr_en,
    input logic [ADDR_W-1:0]        wr_addr,
    input logic                     ldok,
    input logic                     imm,
    input logic                     half_stb,
    input logic                     full_stb,
    input logic                     tick,
    input logic                     load,
    input logic                     out_a,
    input logic                     out_b,
    input logic [DW-1:0]            cnt,
    input logic [NSLOT-1:0][DW-1:0] stage,
    input logic [NSLOT-1:0][DW-1:0] act
);
    // R8: an armed request in immediate mode is gone one clock later
    p_imm_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ldok && imm) |=> !ldok)
        else $error("p_imm_clear_r8");

    // R9: a non-immediate transfer lines up with a boundary strobe
    p_ldok_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ldok) |-> ($past(imm) || half_stb || full_stb))
        else $error("p_ldok_fall_r9");

    // R11: slot writes while armed leave the staging copy untouched
    p_ignore_wr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ldok && wr_en && (wr_addr != ADDR_CTRL)) |=> $stable(stage))
        else $error("p_ignore_wr_r11");

    // R5: the off compare wins over the on compare
    p_clear_wins_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (cnt == act[SLOT_AOFF])) |=> !out_a)
        else $error("p_clear_wins_a_r5");

    p_clear_wins_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (cnt == act[SLOT_BOFF])) |=> !out_b)
        else $error("p_clear_wins_b_r5");

    // R12: the active copy only changes on a transfer
    p_hold_act_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(act))
        else $error("p_hold_act_r12");
endmodule

bind pwm_cmp_gen pwm_cmp_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .ldok     (ldok_o),
    .imm      (imm_q),
    .half_stb (half_stb),
    .full_stb (full_stb),
    .tick     (tick),
    .load     (load),
    .out_a    (out_a),
    .out_b    (out_b),
    .cnt      (cnt),
    .stage    (stage_q),
    .act      (act_q)
);

// File: tb/pwm_cmp_gen_bench.sv
module pwm_cmp_gen_bench;
    typedef struct {
        string req;
        int    val;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        out_a, out_b, half_stb, full_stb, ldok_o;

    int total = 0;
    int bad = 0;
    bit done = 0;
    bit mon_on = 0;
    int cyc = 0;
    int ra = -1, rb = -1, lf = -1, lh = -1;
    bit pa = 0, pb = 0, pl = 0;
    exp_t qa[$], qb[$], qp[$], qh[$], ql[$];

    always #2ns clk = ~clk;

    pwm_cmp_gen u_pwm_cmp_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .out_a(out_a), .out_b(out_b), .half_stb(half_stb), .full_stb(full_stb), .ldok_o(ldok_o)
    );

    function automatic void chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endfunction

    function automatic logic [15:0] ctl(int psc, int imm, int hen, int fen, int every, int ld);
        return 16'((ld << 15) | (every << 6) | (fen << 5) | (hen << 4) | (imm << 3) | psc);
    endfunction

    // monitor: pops expected items as measured events appear
    always @(negedge clk) begin
        exp_t it;
        cyc++;
        if (mon_on) begin
            if (out_a && !pa) ra = cyc;
            if (!out_a && pa && ra >= 0 && qa.size() > 0) begin
                it = qa.pop_front(); chk(it.req, "A high width", cyc - ra, it.val);
            end
            if (out_b && !pb) rb = cyc;
            if (!out_b && pb && rb >= 0 && qb.size() > 0) begin
                it = qb.pop_front(); chk(it.req, "B high width", cyc - rb, it.val);
            end
            if (half_stb) lh = cyc;
            if (full_stb) begin
                if (lf >= 0 && qp.size() > 0) begin
                    it = qp.pop_front(); chk(it.req, "period", cyc - lf, it.val);
                end
                if (lh >= 0 && qh.size() > 0) begin
                    it = qh.pop_front(); chk(it.req, "half-to-full gap", cyc - lh, it.val);
                end
                lf = cyc;
            end
            if (pl && !ldok_o && ql.size() > 0) begin
                it = ql.pop_front(); chk(it.req, "strobe at load-OK fall", {full_stb, half_stb}, it.val);
            end
        end
        pa = out_a; pb = out_b; pl = ldok_o;
    end

    task automatic push(ref exp_t q[$], input string req, input int val);
        exp_t it;
        it.req = req; it.val = val;
        q.push_back(it);
    endtask

    task automatic sb_start();
        @(posedge clk); #1ns;
        ra = -1; rb = -1; lf = -1; lh = -1;
        mon_on = 1;
    endtask

    task automatic drain(ref exp_t q[$]);
        while (q.size() > 0) begin
            exp_t it = q.pop_front();
            total++; bad++;
            $display("FAIL %s event missing: actual=none expected=%0d", it.req, it.val);
        end
    endtask

    task automatic sb_end();
        @(posedge clk); #1ns;
        mon_on = 0;
        drain(qa); drain(qb); drain(qp); drain(qh); drain(ql);
    endtask

    task automatic wr(input int addr, input logic [15:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(addr); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_full();
        do @(negedge clk); while (!full_stb);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        #400us;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset state
        idle(3);
        chk("R1", "out_a in reset", out_a, 0);
        chk("R1", "ldok in reset", ldok_o, 0);
        rst_n = 1'b1;
        idle(3);
        chk("R1", "out_a after reset", out_a, 0);
        chk("R1", "out_b after reset", out_b, 0);
        chk("R1", "ldok after reset", ldok_o, 0);

        // S1: R7 map, R2/R3/R4 unsigned edge-aligned, wrap-boundary load
        wr(7, ctl(0, 0, 0, 1, 0, 0));
        wr(0, 16'd0); wr(1, 16'd5); wr(2, 16'd9);
        wr(3, 16'd2); wr(4, 16'd6); wr(5, 16'd1); wr(6, 16'd8);
        wr(7, ctl(0, 0, 0, 1, 0, 1));
        chk("R11", "ldok set", ldok_o, 1);
        @(negedge clk);
        chk("R11", "ldok self-clear", ldok_o, 0);
        chk("R9", "full strobe at wrap load", full_stb, 1);
        sb_start();
        push(qa, "R4", 4); push(qa, "R4", 4);
        push(qb, "R4", 7); push(qb, "R4", 7);
        push(qp, "R2", 10); push(qp, "R2", 10);
        push(qh, "R3", 4); push(qh, "R3", 4);
        idle(40);
        sb_end();

        // S2: R10 every 4th boundary, R11 ignored write, R12 old values hold
        wr(4, 16'd7);
        sb_start();
        push(ql, "R9", 2);
        wait_full();
        wr(7, ctl(0, 0, 0, 1, 3, 1));
        push(qa, "R12", 4); push(qa, "R12", 4); push(qa, "R12", 4); push(qa, "R12", 4);
        push(qa, "R11", 5); push(qa, "R11", 5);
        wr(4, 16'd3);
        idle(26);
        chk("R10", "ldok still pending", ldok_o, 1);
        idle(20);
        chk("R10", "ldok after 4th boundary", ldok_o, 0);
        idle(30);
        sb_end();

        // S3: R8 immediate transfer
        wr(4, 16'd8);
        wr(7, ctl(0, 1, 0, 1, 0, 1));
        chk("R8", "ldok right after set", ldok_o, 1);
        @(negedge clk);
        chk("R8", "ldok one clock later", ldok_o, 0);
        wait_full();
        sb_start();
        push(qa, "R8", 6); push(qa, "R8", 6);
        idle(30);
        sb_end();

        // S4: R9 half-period boundary only
        wr(7, ctl(0, 0, 1, 0, 0, 0));
        wr(4, 16'd5);
        sb_start();
        push(ql, "R9", 1);
        wr(7, ctl(0, 0, 1, 0, 0, 1));
        idle(25);
        chk("R9", "ldok after half boundary", ldok_o, 0);
        wait_full();
        push(qa, "R9", 3); push(qa, "R9", 3);
        push(qh, "R3", 4); push(qh, "R3", 4);
        idle(30);
        sb_end();

        // S5: R2/R12 signed centre-aligned range, new start applied at the wrap
        wr(7, ctl(0, 0, 0, 1, 0, 0));
        wr(0, -16'sd5); wr(1, 16'd0); wr(2, 16'd4);
        wr(3, -16'sd2); wr(4, 16'd2); wr(5, -16'sd3); wr(6, 16'd3);
        sb_start();
        push(ql, "R9", 2);
        wr(7, ctl(0, 0, 0, 1, 0, 1));
        idle(15);
        wait_full();
        sb_start();
        push(qp, "R12", 10); push(qp, "R2", 10);
        push(qa, "R2", 4); push(qa, "R2", 4);
        push(qb, "R2", 6); push(qb, "R2", 6);
        push(qh, "R3", 4); push(qh, "R3", 4);
        idle(35);
        sb_end();

        // S6: R5 equal on/off gives constant low
        wr(5, 16'd1); wr(6, 16'd1);
        wr(7, ctl(0, 0, 0, 1, 0, 1));
        idle(20);
        begin
            int highs = 0;
            for (int i = 0; i < 30; i++) begin
                @(negedge clk);
                if (out_b) highs++;
            end
            chk("R5", "out_b high cycles", highs, 0);
        end

        // S7: R6 prescale by 4
        wr(7, ctl(2, 0, 0, 1, 0, 0));
        idle(20);
        wait_full();
        sb_start();
        push(qp, "R6", 40); push(qp, "R6", 40);
        push(qa, "R6", 16); push(qa, "R6", 16);
        idle(130);
        sb_end();

        done = 1;
        summary();
        $finish;
    end
endmodule